// File: doc/BRIEF.md
# ADC Serial Configuration Shifter

This block is a synchronous serial engine. It sends a configuration word to an external analog-to-digital converter and collects the bits that the converter returns during the same transfer. Software starts a transfer by writing a 32-bit control word while the block is idle. From that moment the block generates a serial clock, shifts the configuration out most significant bit first, samples the return line, and then raises a one-cycle completion pulse. The received bits appear right-justified in a 16-bit result register.

Two input bits, sampled at the write, select the format. The legacy format sends exactly the low configuration byte. The extended format sends the leading bits of a 16-bit field held in the upper half of the word, and a 7-bit length field in the low bits sets the length, clamped to between 8 and 16 bits. A polarity bit chooses whether the output line changes on the rising or on the falling serial clock edge. Input is always sampled on the other edge. The serial clock is the system clock divided by the even parameter `CLK_DIV`.

Top module: `adccfg_shifter`

## Requirements
- R1: While reset is held and after it is released, `sclk`, `sdo`, `busy` and `done` are 0 and `rx_data` is 0.
- R2: A write (`wr_en`=1) seen while `busy`=0 sets `busy` at the next clock edge. `busy` stays high for exactly N×`CLK_DIV` clock cycles for an N-bit transfer. `done` is high for exactly one cycle, in the cycle in which `busy` has just fallen.
- R3: With `ext_mode`=0 (legacy format), exactly 8 bits are sent: `wr_data[7:0]`, bit 7 first. Bits [31:16] have no effect, and neither does the value of bits [6:0] as a length.
- R4: With `ext_mode`=1 (extended format), N = `wr_data[6:0]` clamped into 8..16 (values below 8 give 8, values above 16 give 16). The N most significant bits of `wr_data[31:16]` are sent, bit 31 first.
- R5: With `edge_sel`=1, `sdo` changes only on a rising `sclk` edge, and `sdi` is sampled on each falling `sclk` edge.
- R6: With `edge_sel`=0, the first bit is on `sdo` from the cycle after the write. `sdo` then changes only on falling `sclk` edges, and `sdi` is sampled on each rising `sclk` edge.
- R7: `sclk` has period `CLK_DIV` system cycles and gives exactly N pulses per transfer. It is low whenever `busy` is low. After a transfer `sdo` keeps the last bit sent.
- R8: A write that arrives while `busy`=1 is ignored. The running transfer is unchanged, and no new transfer follows it.
- R9: At `done`, `rx_data` holds the N sampled bits right-justified: the first bit sampled is at bit N-1 and the bits above N-1 are 0. `rx_data` changes at no other time.
- R10: `ext_mode` and `edge_sel` take effect only when a transfer starts. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: extension field [31:16], byte [7:0], length [6:0] |
| ext_mode | input | 1 | 1 selects the extended format, 0 selects the legacy format |
| edge_sel | input | 1 | 1 launches on the rising edge, 0 launches on the falling edge |
| sdi | input | 1 | Serial data returned by the converter |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial configuration data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 16 | Received bits, right-justified |

## Verification
The assertions assume that `sdi` is stable around each system clock edge on which a sampling `sclk` edge is produced, and that writes are single-cycle strobes. The stimulus meets both conditions. A bench model of the converter changes `sdi` only a short delay after a sampling edge, and drives `wr_en` away from the clock edge for one cycle at a time. The writes that arrive during a transfer flip both mode inputs and invert the data, so the assertions see a stable configuration only if the block really latches it. `CLK_DIV` is assumed to be even and at least 2. The bench uses 4, so that it can inject writes between serial edges.

// File: rtl/adccfg_pkg.sv
package adccfg_pkg;

    localparam int REG_W     = 32;
    localparam int EXT_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int LEN_FLD_W = 7;
    localparam int LEN_MIN   = 8;
    localparam int LEN_MAX   = 16;
    localparam int CNT_W     = $clog2(LEN_MAX + 1);

    typedef logic [EXT_W-1:0] frame_t;
    typedef logic [CNT_W-1:0] len_t;

    typedef enum logic {
        LAUNCH_ON_FALL = 1'b0,
        LAUNCH_ON_RISE = 1'b1
    } pol_e;

    typedef struct packed {
        pol_e   pol;
        len_t   len;
        frame_t frame;
    } xfer_cfg_t;

    function automatic len_t clamp_len(input logic [LEN_FLD_W-1:0] raw);
        if (raw < LEN_FLD_W'(LEN_MIN)) return len_t'(LEN_MIN);
        if (raw > LEN_FLD_W'(LEN_MAX)) return len_t'(LEN_MAX);
        return len_t'(raw);
    endfunction

    // Frame is left-aligned so that the first bit to send is always bit EXT_W-1.
    function automatic xfer_cfg_t decode_cfg(input logic [REG_W-1:0] w,
                                             input logic ext,
                                             input logic pol_bit);
        xfer_cfg_t c;
        c.pol = pol_bit ? LAUNCH_ON_RISE : LAUNCH_ON_FALL;
        if (ext) begin
            c.len   = clamp_len(w[LEN_FLD_W-1:0]);
            c.frame = w[REG_W-1 -: EXT_W];
        end else begin
            c.len   = len_t'(BYTE_W);
            c.frame = {w[BYTE_W-1:0], {(EXT_W-BYTE_W){1'b0}}};
        end
        return c;
    endfunction

endpackage

// File: rtl/adccfg_sclk_gen.sv
module adccfg_sclk_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] hcnt;
    logic          wrap;

    assign wrap    = run && (hcnt == CW'(HALF - 1));
    assign rise_ev = wrap && !sclk;
    assign fall_ev = wrap &&  sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            hcnt <= '0;
            sclk <= ~sclk;
        end else begin
            hcnt <= hcnt + CW'(1);
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |-> !sclk);  // R7

    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (run && $rose(sclk)) |=> sclk);  // R7

endmodule

// File: rtl/adccfg_ctrl.sv
module adccfg_ctrl
    import adccfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ext_mode,
    input  logic             edge_sel,
    input  logic             fall_ev,
    output logic             busy,
    output logic             done,
    output logic             start,
    output xfer_cfg_t        nxt_cfg,
    output xfer_cfg_t        cfg,
    output logic             last_bit
);
    len_t bitcnt;
    logic finish;

    assign start    = wr_en && !busy;
    assign nxt_cfg  = decode_cfg(wr_data, ext_mode, edge_sel);
    assign last_bit = (bitcnt == len_t'(cfg.len - len_t'(1)));
    assign finish   = busy && fall_ev && last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            bitcnt <= '0;
            cfg    <= '{pol: LAUNCH_ON_FALL, len: len_t'(LEN_MIN), frame: '0};
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                bitcnt <= '0;
                cfg    <= nxt_cfg;
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (busy && fall_ev) begin
                bitcnt <= bitcnt + len_t'(1);
            end
        end
    end

    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cfg.len >= len_t'(LEN_MIN) && cfg.len <= len_t'(LEN_MAX)));  // R4

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && !(fall_ev && last_bit)) |=> busy && !done);  // R8

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));  // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R2

    AST_DONE_ON_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);  // R2

endmodule

// File: rtl/adccfg_shift.sv
module adccfg_shift
    import adccfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  pol_e   start_pol,
    input  frame_t start_frame,
    input  pol_e   pol,
    input  logic   busy,
    input  logic   rise_ev,
    input  logic   fall_ev,
    input  logic   last_bit,
    input  logic   sdi,
    output logic   sdo,
    output frame_t rx_data
);
    frame_t tx_sr;
    frame_t rx_sr;
    logic   launch_ev;
    logic   sample_ev;
    logic   finish;

    assign launch_ev = busy && ((pol == LAUNCH_ON_RISE) ? rise_ev : (fall_ev && !last_bit));
    assign sample_ev = busy && ((pol == LAUNCH_ON_RISE) ? fall_ev : rise_ev);
    assign finish    = busy && fall_ev && last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            sdo     <= 1'b0;
            rx_data <= '0;
        end else if (start) begin
            rx_sr <= '0;
            if (start_pol == LAUNCH_ON_FALL) begin
                sdo   <= start_frame[EXT_W-1];
                tx_sr <= start_frame << 1;
            end else begin
                tx_sr <= start_frame;
            end
        end else begin
            if (launch_ev) begin
                sdo   <= tx_sr[EXT_W-1];
                tx_sr <= tx_sr << 1;
            end
            if (sample_ev) begin
                rx_sr <= {rx_sr[EXT_W-2:0], sdi};
            end
            if (finish) begin
                rx_data <= (pol == LAUNCH_ON_RISE) ? {rx_sr[EXT_W-2:0], sdi} : rx_sr;
            end
        end
    end

    AST_NO_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(sdo));  // R7

endmodule

// File: rtl/adccfg_shifter.sv
module adccfg_shifter
    import adccfg_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        ext_mode,
    input  logic        edge_sel,
    input  logic        sdi,
    output logic        sclk,
    output logic        sdo,
    output logic        busy,
    output logic        done,
    output logic [15:0] rx_data
);
    logic      start;
    logic      last_bit;
    logic      rise_ev;
    logic      fall_ev;
    xfer_cfg_t nxt_cfg;
    xfer_cfg_t cfg;

    adccfg_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ext_mode (ext_mode),
        .edge_sel (edge_sel),
        .fall_ev  (fall_ev),
        .busy     (busy),
        .done     (done),
        .start    (start),
        .nxt_cfg  (nxt_cfg),
        .cfg      (cfg),
        .last_bit (last_bit)
    );

    adccfg_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .sclk    (sclk),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    adccfg_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_pol   (nxt_cfg.pol),
        .start_frame (nxt_cfg.frame),
        .pol         (cfg.pol),
        .busy        (busy),
        .rise_ev     (rise_ev),
        .fall_ev     (fall_ev),
        .last_bit    (last_bit),
        .sdi         (sdi),
        .sdo         (sdo),
        .rx_data     (rx_data)
    );

    AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdo) && !$past(start)) |->
            ((cfg.pol == LAUNCH_ON_RISE) ? $rose(sclk) : $fell(sclk)));  // R5 R6

    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rx_data));  // R9

endmodule

// File: tb/adccfg_shifter_test.sv
`timescale 1ns/1ps
module adccfg_shifter_test;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ext_mode = 1'b0;
    logic        edge_sel = 1'b0;
    logic        sdi = 1'b0;
    logic        sclk, sdo, busy, done;
    logic [15:0] rx_data;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [15:0] rx;
        logic [15:0] tx;
        int          n;
    } item_t;

    item_t       sb_q[$];
    logic [15:0] cap_tx;
    int          cap_n;
    int          bcnt = 0;
    logic [15:0] prev_rx = '0;

    adccfg_shifter #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ext_mode(ext_mode), .edge_sel(edge_sel), .sdi(sdi),
        .sclk(sclk), .sdo(sdo), .busy(busy), .done(done), .rx_data(rx_data)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: counts busy cycles and scores each completion against the queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) bcnt++;
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected done", 32'(done), 32'h0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(cap_tx == it.tx, "R3/R4 sent bits", 32'(cap_tx), 32'(it.tx));
                    check(cap_n == it.n, "R7 sclk pulse count", 32'(cap_n), 32'(it.n));
                    check(rx_data == it.rx, "R9 received word", 32'(rx_data), 32'(it.rx));
                    check(bcnt == it.n * DIV, "R2 busy length", 32'(bcnt), 32'(it.n * DIV));
                    prev_rx = it.rx;
                end
                bcnt = 0;
            end
        end
    end

    // Driver and converter model for one transfer.
    task automatic run_xfer(input logic ext, input logic pol, input logic [31:0] w,
                            input logic [15:0] resp, input bit poke);
        int          n;
        logic [15:0] tx_exp;
        logic [15:0] rx_exp;
        bit          idle_ok;
        item_t       it;
        if (ext) begin
            n = (w[6:0] < 7'd8) ? 8 : (w[6:0] > 7'd16) ? 16 : int'(w[6:0]);
            tx_exp = w[31:16] >> (16 - n);
        end else begin
            n = 8;
            tx_exp = {8'h00, w[7:0]};
        end
        rx_exp = resp & 16'((32'h1 << n) - 1);
        it.rx = rx_exp; it.tx = tx_exp; it.n = n;
        sb_q.push_back(it);
        cap_tx = '0;
        cap_n = 0;
        sdi = resp[n-1];
        @(negedge clk);
        wr_en = 1'b1; wr_data = w; ext_mode = ext; edge_sel = pol;
        @(negedge clk);
        wr_en = 1'b0;
        check(busy == 1'b1, "R2 busy after write", 32'(busy), 32'h1);
        check(rx_data == prev_rx, "R9 result held during transfer", 32'(rx_data), 32'(prev_rx));
        if (!pol) check(sdo == tx_exp[n-1], "R6 first bit before first edge", 32'(sdo), 32'(tx_exp[n-1]));
        for (int i = 0; i < n; i++) begin
            if (pol) @(negedge sclk); else @(posedge sclk);
            cap_tx = {cap_tx[14:0], sdo};
            cap_n++;
            #1;
            sdi = (i + 1 < n) ? resp[n-2-i] : 1'b0;
            if (poke && i == 2) begin
                // R8 / R10: inverted data and flipped modes while busy
                @(negedge clk);
                wr_en = 1'b1; wr_data = ~w; ext_mode = ~ext; edge_sel = ~pol;
                @(negedge clk);
                wr_en = 1'b0;
            end
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check(sclk == 1'b0, "R7 sclk idle low", 32'(sclk), 32'h0);
        check(sdo == tx_exp[0], "R7 sdo holds last bit", 32'(sdo), 32'(tx_exp[0]));
        idle_ok = 1'b1;
        repeat (2 * DIV) begin
            @(negedge clk);
            if (busy) idle_ok = 1'b0;
        end
        check(idle_ok, "R8 no transfer follows", 32'(!idle_ok), 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sclk == 0 && sdo == 0 && busy == 0 && done == 0 && rx_data == 0,
              "R1 reset state", {sclk, sdo, busy, done, rx_data}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(sclk == 0 && sdo == 0 && busy == 0 && done == 0 && rx_data == 0,
              "R1 after release", {sclk, sdo, busy, done, rx_data}, 32'h0);
        // R3 legacy, launch on falling edge (R6); upper field and length bits ignored
        run_xfer(1'b0, 1'b0, 32'hABCD_00A5, 16'h5A3C, 1'b0);
        // R3 legacy, launch on rising edge (R5)
        run_xfer(1'b0, 1'b1, 32'hFFFF_0071, 16'h00C3, 1'b0);
        // R4 extended, length 12
        run_xfer(1'b1, 1'b1, {16'hB7E1, 9'h0, 7'd12}, 16'h0ABC, 1'b0);
        // R4 extended, length 3 clamps to 8
        run_xfer(1'b1, 1'b0, {16'h9C40, 9'h0, 7'd3}, 16'h00E7, 1'b0);
        // R4 extended, length 100 clamps to 16
        run_xfer(1'b1, 1'b1, {16'hC0DE, 9'h0, 7'd100}, 16'h8001, 1'b0);
        // R8 R10 extended length 9 with a write during the transfer
        run_xfer(1'b1, 1'b0, {16'h1234, 9'h0, 7'd9}, 16'h01F5, 1'b1);
        // R8 R10 legacy with a write during the transfer
        run_xfer(1'b0, 1'b1, 32'h0000_0096, 16'h0069, 1'b1);
        // R4 extended, length 0 clamps to 8
        run_xfer(1'b1, 1'b0, {16'h5AF0, 9'h0, 7'd0}, 16'h00FF, 1'b0);
        check(sb_q.size() == 0, "R2 every transfer completed", 32'(sb_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule